// File: doc/BRIEF.md
# Four-Channel Serial Audio Frame Transceiver

This block connects a device to a one-way serial audio link built from three lines: a bit clock, a frame marker and a data line. Each frame carries four 16-bit channel samples, 64 bits in all. The block collects incoming bits into a 64-bit shift register. When the frame marker is asserted, it hands the collected frame to the local side as a parallel word. On the same event it loads a parallel word from the local side and shifts that word out on its own data output. Several devices can form a chain: the clock and the frame marker go to every device, and the data line passes from one device to the next.

The block runs from one main clock. The serial lines are brought into that clock domain through synchronisers, and their edges are detected there. In follower mode the link clock and frame marker come from outside, and the block also drives delayed copies of them on its outputs. In leader mode the block generates both signals itself from the main clock and ignores the two clock and marker inputs. One control pin places all serial outputs in high impedance, and that pin comes up asserted from reset.

Both parallel sides use valid/ready handshakes. On the receive side a frame waits until the consumer accepts it. If the next frame closes first, it replaces the waiting frame, because the link cannot stall. On the transmit side one staging word is held. `tx_ready` is low while the staging word is full and rises again when that word moves into the output shift register. A frame that closes while the staging word is empty transmits zeros.

Top module: `sfx_xcvr`

## Requirements
- R1: Serial bits arrive least significant bit first. After a frame closes, the first bit received in that frame is at bit 0 of `rx_samples`, and channel n occupies bits 16n+15 down to 16n (channel 0 is the lowest).
- R2: A frame closes when the synchronised frame marker falls, since the marker is active low. On that event `rx_samples` is loaded, `rx_valid` is set, and `rx_strobe` goes high for exactly one main-clock cycle.
- R3: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_samples` stays stable. The only exception is a newly closed frame, which replaces the held one. With `rx_ready` high, `rx_valid` clears on the next clock edge.
- R4: `tx_ready` is high exactly when the staging word is empty. A word offered while `tx_ready` is low is ignored. The staging word moves to the output shift register at the next frame close. If the staging word is empty at that point, the frame transmits all zeros.
- R5: After a frame close, `ser_dat_o` presents bit 0 of the loaded word. It advances one bit on each falling edge of the link clock, least significant bit first, and changes at no other time.
- R6: In follower mode, `ser_clk_o` and `ser_id_o` follow `ser_clk_i` and `ser_id_i` through the two-stage synchroniser, delayed by two main clocks.
- R7: In leader mode (`cfg_master` = 1), `ser_clk_o` is the main clock divided by CLK_DIV, with equal high and low times. `ser_id_o` goes low for one link-clock period after every 64 link-clock periods. `ser_clk_i` and `ser_id_i` have no effect.
- R8: `ser_oe` is the inverse of `cfg_hiz`. A value of 1 on `cfg_hiz` puts all serial outputs in high impedance.
- R9: After reset, the outputs take these values: `rx_valid`=0, `rx_strobe`=0, `tx_ready`=1, `ser_dat_o`=0, `ser_clk_o`=0, `ser_id_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; must be at least four times the link clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: leader mode, the block generates clock and frame marker |
| cfg_hiz | input | 1 | 1: serial outputs placed in high impedance |
| ser_clk_i | input | 1 | Link bit clock from an external leader |
| ser_id_i | input | 1 | Active-low frame marker from an external leader |
| ser_dat_i | input | 1 | Serial data from the upstream device |
| ser_clk_o | output | 1 | Link clock, passed through or generated |
| ser_id_o | output | 1 | Frame marker, passed through or generated |
| ser_dat_o | output | 1 | Serial data to the downstream device |
| ser_oe | output | 1 | Output enable for the three serial outputs |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Staging word empty, transmit word will be taken |
| tx_samples | input | 64 | Transmit word, channel n at bits 16n+15:16n |
| rx_valid | output | 1 | Received frame waiting |
| rx_ready | input | 1 | Consumer accepts the received frame |
| rx_samples | output | 64 | Received word, channel n at bits 16n+15:16n |
| rx_strobe | output | 1 | One-cycle pulse when a frame is latched |

## Verification
The hardest case to reach from the ports is the collision between link timing and local back-pressure. One such collision is a frame that closes while an earlier frame is still unaccepted. Another is a transmit word offered while the staging word is still full. The stimulus drives the link as a cycle-exact follower waveform and holds `rx_ready` low across two frame closes, so the replacement rule is observed. It also offers a second transmit word while `tx_ready` is low, then checks which word actually leaves on the data line. Leader mode is reached by enabling it with a staged word already loaded, so the first generated frame has a known start. A bench-side upstream device then answers each generated clock fall with the next bit.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  // Event strobes that drive the frame engines, one main-clock cycle each.
  typedef struct packed {
    logic cap;    // sample the serial input bit
    logic shift;  // advance the serial output bit
    logic frame;  // frame close: latch receive word, load transmit word
  } sfx_evt_t;
endpackage

// File: rtl/sfx_sync.sv
module sfx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfx_master_gen.sv
module sfx_master_gen #(
  parameter int DIV     = 4,
  parameter int FRAME_W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk,
  output logic ident,
  output logic fall_evt,
  output logic frame_evt
);
  localparam int PH_W  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CNT_W = $clog2(FRAME_W);

  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] bit_cnt;
  logic             rise_evt;

  assign fall_evt  = en && (ph == '0);
  assign rise_evt  = en && (ph == PH_W'(DIV / 2));
  assign frame_evt = fall_evt && (bit_cnt == CNT_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= '0;
      bit_cnt <= '0;
      sclk    <= 1'b0;
      ident   <= 1'b1;
    end else if (!en) begin
      ph      <= '0;
      bit_cnt <= '0;
      sclk    <= 1'b0;
      ident   <= 1'b1;
    end else begin
      ph <= (ph == PH_W'(DIV - 1)) ? '0 : ph + 1'b1;
      if (fall_evt) bit_cnt <= bit_cnt + 1'b1;
      if (rise_evt)      sclk <= 1'b1;
      else if (fall_evt) sclk <= 1'b0;
      if (frame_evt)     ident <= 1'b0;
      else if (fall_evt) ident <= 1'b1;
    end
  end

  // R7: the marker stays low for one link-clock period only
  assert_ident_one_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ident && fall_evt) |=> ident);

  // R7: each high phase of the generated clock lasts more than one main clock
  assert_sclk_high_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $rose(sclk)) |=> (sclk || !en));
endmodule

// File: rtl/sfx_rx.sv
module sfx_rx #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_evt,
  input  logic               frame_evt,
  input  logic               din,
  input  logic               rx_ready,
  output logic               rx_valid,
  output logic [FRAME_W-1:0] rx_data,
  output logic               rx_strobe
);
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] shreg_next;

  // least significant bit first: each new bit enters at the top and moves down
  assign shreg_next = cap_evt ? {din, shreg[FRAME_W-1:1]} : shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      rx_strobe <= 1'b0;
    end else begin
      shreg     <= shreg_next;
      rx_strobe <= frame_evt;
      if (frame_evt) begin
        rx_data  <= shreg_next;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R3: an unaccepted frame is held unless a new frame replaces it
  assert_rx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !frame_evt) |=> (rx_valid && $stable(rx_data)));

  // R2: the strobe lasts a single cycle and comes with valid data
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);
  assert_strobe_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> rx_valid);
endmodule

// File: rtl/sfx_tx.sv
module sfx_tx #(
  parameter int FRAME_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_evt,
  input  logic               frame_evt,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               tx_ready,
  output logic               dout
);
  logic [FRAME_W-1:0] stage;
  logic               stage_full;
  logic [FRAME_W-1:0] oreg;
  logic               accept;

  assign tx_ready = !stage_full;
  assign accept   = tx_valid && !stage_full;
  assign dout     = oreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= '0;
      stage_full <= 1'b0;
      oreg       <= '0;
    end else begin
      if (accept)         stage <= tx_data;
      if (accept)         stage_full <= 1'b1;
      else if (frame_evt) stage_full <= 1'b0;
      if (frame_evt)      oreg <= stage_full ? stage : '0;
      else if (shift_evt) oreg <= {1'b0, oreg[FRAME_W-1:1]};
    end
  end

  // R5: the data line moves only on a shift or frame event
  assert_dout_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_evt && !frame_evt) |=> $stable(dout));

  // R4: a full staging word stays full until a frame takes it
  assert_ready_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !frame_evt) |=> !tx_ready);
endmodule

// File: rtl/sfx_xcvr.sv
module sfx_xcvr
  import sfx_pkg::*;
#(
  parameter int CH_NUM      = 4,
  parameter int SAMPLE_W    = 16,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W    = CH_NUM * SAMPLE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_master,
  input  logic               cfg_hiz,
  input  logic               ser_clk_i,
  input  logic               ser_id_i,
  input  logic               ser_dat_i,
  output logic               ser_clk_o,
  output logic               ser_id_o,
  output logic               ser_dat_o,
  output logic               ser_oe,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [FRAME_W-1:0] tx_samples,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [FRAME_W-1:0] rx_samples,
  output logic               rx_strobe
);
  localparam int         N_LINES  = 3;
  localparam logic [2:0] LINE_RST = 3'b010;  // {data, ident, clock} idle levels

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_s;
  logic [N_LINES-1:0] line_q;

  assign line_raw = {ser_dat_i, ser_id_i, ser_clk_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    sfx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_RST[g])) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (line_raw[g]),
      .q    (line_s[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= LINE_RST;
    else        line_q <= line_s;
  end

  logic s_rise, s_fall, s_idfall;
  assign s_rise   =  line_s[0] && !line_q[0];
  assign s_fall   = !line_s[0] &&  line_q[0];
  assign s_idfall = !line_s[1] &&  line_q[1];

  logic m_sclk, m_ident, m_fall, m_frame;

  sfx_master_gen #(.DIV(CLK_DIV), .FRAME_W(FRAME_W)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_master),
    .sclk     (m_sclk),
    .ident    (m_ident),
    .fall_evt (m_fall),
    .frame_evt(m_frame)
  );

  sfx_evt_t evt;
  always_comb begin
    if (cfg_master) begin
      // leader: sample at the fall, which compensates the input synchroniser delay
      evt.cap   = m_fall;
      evt.shift = m_fall;
      evt.frame = m_frame;
    end else begin
      evt.cap   = s_rise;
      evt.shift = s_fall;
      evt.frame = s_idfall;
    end
  end

  sfx_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_evt  (evt.cap),
    .frame_evt(evt.frame),
    .din      (line_s[2]),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_samples),
    .rx_strobe(rx_strobe)
  );

  sfx_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_evt(evt.shift),
    .frame_evt(evt.frame),
    .tx_valid (tx_valid),
    .tx_data  (tx_samples),
    .tx_ready (tx_ready),
    .dout     (ser_dat_o)
  );

  assign ser_clk_o = cfg_master ? m_sclk  : line_s[0];
  assign ser_id_o  = cfg_master ? m_ident : line_s[1];
  assign ser_oe    = !cfg_hiz;

  // R7: in leader mode a frame close comes only from the generator
  assert_master_frame_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && s_idfall && !m_frame) |=> !rx_strobe);
endmodule

// File: tb/sfx_xcvr_bench.sv
module sfx_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_master, cfg_hiz;
  logic ser_clk_i, ser_id_i, ser_dat_i;
  logic ser_clk_o, ser_id_o, ser_dat_o, ser_oe;
  logic tx_valid, tx_ready;
  logic [FW-1:0] tx_samples;
  logic rx_valid, rx_ready, rx_strobe;
  logic [FW-1:0] rx_samples;

  sfx_xcvr u_sfx_xcvr (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_hiz(cfg_hiz),
    .ser_clk_i(ser_clk_i), .ser_id_i(ser_id_i), .ser_dat_i(ser_dat_i),
    .ser_clk_o(ser_clk_o), .ser_id_o(ser_id_o), .ser_dat_o(ser_dat_o), .ser_oe(ser_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_samples(tx_samples),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_samples(rx_samples), .rx_strobe(rx_strobe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit reported = 1'b0;
  int strobe_cnt = 0;

  always @(posedge clk) if (rst_n && rx_strobe) strobe_cnt <= strobe_cnt + 1;

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    end
  endtask

  function automatic logic [FW-1:0] rand_word();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [FW-1:0] pack4(input logic [15:0] c3, c2, c1, c0);
    return {c3, c2, c1, c0};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // results collected by one follower-mode frame
  logic [FW-1:0] got_tx, got_rx;
  bit got_valid;
  int pass_err;

  // One follower frame; bit 0's low phase carries the frame marker that closes the previous frame.
  task automatic slave_frame(input logic [FW-1:0] w);
    pass_err = 0;
    for (int i = 0; i < FW; i++) begin
      ser_clk_i = 1'b0;
      ser_dat_i = w[i];
      ser_id_i  = (i == 0) ? 1'b0 : 1'b1;
      wait_n(2);
      if (ser_clk_o !== 1'b0) pass_err++;
      if (i == 0 && ser_id_o !== 1'b0) pass_err++;
      if (i == 1 && ser_id_o !== 1'b1) pass_err++;
      ser_clk_i = 1'b1;
      wait_n(2);
      if (ser_clk_o !== 1'b1) pass_err++;
      got_tx[i] = ser_dat_o;
      if (i == 0) begin
        got_rx    = rx_samples;
        got_valid = rx_valid;
      end
    end
  endtask

  task automatic push_tx(input logic [FW-1:0] w);
    tx_samples = w;
    tx_valid   = 1'b1;
    @(negedge clk);
    tx_valid   = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    report();
    $finish;
  end

  initial begin
    logic [FW-1:0] prev_w, cur_w, tx_w, mw, tm, m_tx;
    int s0, lo_err, fidx, hi_len, lo_len, id_len, frames, guard;
    bit prev_sclk, prev_id;

    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; cfg_master = 1'b0; cfg_hiz = 1'b1;
    ser_clk_i = 1'b0; ser_id_i = 1'b1; ser_dat_i = 1'b0;
    tx_valid = 1'b0; tx_samples = '0; rx_ready = 1'b1;
    wait_n(4);
    // R9 reset values
    check(rx_valid === 1'b0 && rx_strobe === 1'b0, "R9 rx reset", {62'd0, rx_valid, rx_strobe}, '0);
    check(tx_ready === 1'b1 && ser_dat_o === 1'b0, "R9 tx reset", {62'd0, tx_ready, ser_dat_o}, 64'd2);
    check(ser_clk_o === 1'b0 && ser_id_o === 1'b1, "R9 line reset", {62'd0, ser_clk_o, ser_id_o}, 64'd1);
    check(ser_oe === 1'b0, "R8 hiz after reset", {63'd0, ser_oe}, '0);
    rst_n = 1'b1;
    wait_n(3);
    cfg_hiz = 1'b0;
    wait_n(1);
    check(ser_oe === 1'b1, "R8 outputs enabled", {63'd0, ser_oe}, 64'd1);

    // first frame: directed channel pattern, transmit a known word
    tx_w = pack4(16'hD4D4, 16'hC3C3, 16'hB2B2, 16'hA1A1);
    push_tx(tx_w);
    check(tx_ready === 1'b0, "R4 staging full", {63'd0, tx_ready}, '0);
    prev_w = pack4(16'h4444, 16'h3333, 16'h2222, 16'h1111);
    s0 = strobe_cnt;
    slave_frame(prev_w);
    check(got_tx === tx_w, "R5 serial out order", got_tx, tx_w);
    check(tx_ready === 1'b1, "R4 staging freed at frame", {63'd0, tx_ready}, 64'd1);
    check(pass_err == 0, "R6 follower pass-through", pass_err, 0);

    // random frames, one without a staged word
    for (int k = 1; k <= 6; k++) begin
      cur_w = (k == 5) ? {FW{1'b1}} : rand_word();
      tx_w  = (k == 3) ? '0 : rand_word();
      if (k != 3) push_tx(tx_w);
      s0 = strobe_cnt;
      slave_frame(cur_w);
      check(got_rx === prev_w, "R1 receive word", got_rx, prev_w);
      if (k == 1)
        check(got_rx[15:0] === 16'h1111 && got_rx[63:48] === 16'h4444, "R1 channel placement",
              got_rx, prev_w);
      check(strobe_cnt == s0 + 1, "R2 one strobe per frame", strobe_cnt - s0, 1);
      check(got_tx === tx_w, (k == 3) ? "R4 empty staging sends zeros" : "R5 serial out",
            got_tx, tx_w);
      check(pass_err == 0, "R6 follower pass-through", pass_err, 0);
      prev_w = cur_w;
    end
    check(rx_valid === 1'b0, "R3 valid cleared when ready", {63'd0, rx_valid}, '0);

    // back-pressure: hold across two frame closes
    rx_ready = 1'b0;
    tx_w = rand_word();
    push_tx(tx_w);
    // a second offer while full must be ignored
    tx_samples = ~tx_w; tx_valid = 1'b1;
    wait_n(2);
    tx_valid = 1'b0;
    check(tx_ready === 1'b0, "R4 refused while full", {63'd0, tx_ready}, '0);
    cur_w = rand_word();
    slave_frame(cur_w);
    check(got_tx === tx_w, "R4 refused word not sent", got_tx, tx_w);
    check(rx_valid === 1'b1 && rx_samples === prev_w, "R3 held frame", rx_samples, prev_w);
    prev_w = cur_w;
    cur_w = rand_word();
    slave_frame(cur_w);
    check(got_valid && got_rx === prev_w, "R3 newer frame replaces held", got_rx, prev_w);
    check(rx_valid === 1'b1, "R3 still valid while not ready", {63'd0, rx_valid}, 64'd1);
    rx_ready = 1'b1;
    wait_n(1);
    check(rx_valid === 1'b0, "R3 accepted", {63'd0, rx_valid}, '0);

    // leader mode
    m_tx = rand_word();
    mw   = rand_word();
    push_tx(m_tx);
    ser_clk_i = 1'b0; ser_id_i = 1'b1;
    cfg_master = 1'b1;
    prev_sclk = ser_clk_o; prev_id = ser_id_o;
    fidx = -1; frames = 0; hi_len = 0; lo_len = 0; id_len = 0; lo_err = 0; tm = '0;
    guard = 0;
    s0 = strobe_cnt;
    while (frames < 2 && guard < 2000) begin
      @(negedge clk);
      guard++;
      // garbage on the ignored inputs
      ser_clk_i = $urandom_range(0, 1);
      ser_id_i  = $urandom_range(0, 1);
      if (ser_clk_o) hi_len++; else lo_len++;
      if (!ser_id_o) id_len++;
      if (prev_sclk && !ser_clk_o) begin
        if (fidx >= 0 && hi_len != 2) lo_err++;
        hi_len = 0;
        if (!ser_id_o && prev_id) begin
          frames++;
          fidx = 0;
        end
        if (fidx >= 0 && fidx < FW) ser_dat_i = mw[fidx];
        if (fidx >= 0) fidx++;
      end
      if (!prev_sclk && ser_clk_o) begin
        if (fidx > 0 && lo_len != 2) lo_err++;
        lo_len = 0;
        if (frames == 1 && fidx >= 1 && fidx <= FW) tm[fidx-1] = ser_dat_o;
      end
      if (ser_id_o && !prev_id) begin
        if (id_len != 4) lo_err++;
        id_len = 0;
      end
      prev_sclk = ser_clk_o; prev_id = ser_id_o;
    end
    wait_n(2);
    check(frames == 2, "R7 leader frames generated", frames, 2);
    check(lo_err == 0, "R7 leader clock and marker timing", lo_err, 0);
    check(rx_samples === mw, "R7 leader receive word", rx_samples, mw);
    check(tm === m_tx, "R5 leader serial out", tm, m_tx);
    check(strobe_cnt == s0 + 2, "R7 strobes ignore input marker", strobe_cnt - s0, 2);

    cfg_hiz = 1'b1;
    wait_n(1);
    check(ser_oe === 1'b0, "R8 outputs released", {63'd0, ser_oe}, '0);
    report();
    $finish;
  end
endmodule